// File: doc/BRIEF.md
# USB Host Frame Timer and List Scheduler

This block keeps the frame clock of a full-speed USB host root port and tells the rest of the host controller which class of list may start its next transaction. A 14-bit remaining-time counter counts down one step per full-speed bit-time tick. When it runs out it reloads from a programmable frame interval, and the 16-bit frame number advances. A fixed boundary sequence then follows: a start-of-frame pulse, a strobe that publishes the new frame number, and finally a sticky start-of-frame status flag.

Two compares against the live countdown shape scheduling within a frame. Once the remaining time falls to the periodic-start threshold, control and bulk lists lose the right to begin new work. The interrupt list is granted only after any control or bulk transaction already underway has finished and the boundary sequence is complete. A second, 11-bit threshold decides whether a worst-case 8-byte low-speed packet may still begin before end of frame. Once that window closes, a denial is held for the rest of the frame. Configuration arrives through a simple write port. The frame number itself is presented on an output for the memory-writing logic that lies outside this block.

Top module: `usb_frame_sched`

## Requirements
- R1: After reset the remaining time and frame number are 0, and no SOF pulse, status flag or grant is active. The frame interval resets to 11999. The periodic-start threshold resets to 0, so with no write, periodic priority appears only after the countdown has reached 0.
- R2: When `run` rises, the remaining time loads the frame interval on the next clock, and the frame number advances by one.
- R3: While running, the remaining time drops by exactly one per clock in which `bit_tick` is high. It holds its value when `bit_tick` is low.
- R4: A tick while the remaining time is 0 reloads the frame interval and advances the frame number by one. The frame number wraps from 0xFFFF to 0.
- R5: After every reload, `sof_pulse` is high for the next cycle, `fn_pub_valid` is high in the cycle after that, and `sof_status` becomes 1 two cycles after `fn_pub_valid`.
- R6: `sof_status` stays set until a write to address 3 with data bit 0 equal to 1 clears it. A write there with bit 0 equal to 0 leaves it set.
- R7: In the cycle after the remaining time is at or below the periodic-start threshold (address 1), `cb_allow` goes low.
- R8: `per_grant` rises only after periodic priority is pending, `txn_busy` is low, and the boundary sequence of R5 has finished.
- R9: Every reload clears periodic priority: the cycle after a reload shows `per_grant` low and `cb_allow` high.
- R10: `ls_ok` is high only while running, with the remaining time strictly above the low-speed threshold (address 2), and with no denial yet in this frame. `ls_denied` rises the cycle after the remaining time is at or below the threshold and stays high until the next reload.
- R11: The low-speed threshold (reset value 1576) accepts only the first write after reset. Later writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Write address: 0 interval, 1 periodic start, 2 low-speed threshold, 3 status clear |
| cfg_wdata | input | 14 | Write data |
| run | input | 1 | Port operational; its rise starts the first frame |
| bit_tick | input | 1 | One full-speed bit time has elapsed |
| txn_busy | input | 1 | A control or bulk transaction is in progress |
| remaining | output | 14 | Live remaining-time count |
| frame_num | output | 16 | Current frame number |
| sof_pulse | output | 1 | Start-of-frame event |
| fn_pub_valid | output | 1 | Frame number on `frame_num` is to be published |
| sof_status | output | 1 | Sticky start-of-frame status |
| cb_allow | output | 1 | Control and bulk lists may start new work |
| per_grant | output | 1 | Interrupt list may start |
| ls_ok | output | 1 | A low-speed packet may be committed now |
| ls_denied | output | 1 | Low-speed commits refused for the rest of this frame |

## Verification
The bench holds `txn_busy` high across the moment periodic priority arrives. A design that preempted in-flight work would raise `per_grant` too early. The bench also sets the periodic threshold equal to the interval, so priority is pending during the boundary sequence; a design that ignored the sequence would grant the interrupt list before the status flag is set. The low-speed gate is probed one count above and exactly at the threshold. The bench then attempts a second threshold write, which a design without the write lock would accept, reopening the window. An interval of 0 drives one frame per clock, so the frame number crosses 0xFFFF. An off-by-one in the reload compare or a wrong counter width would show up as a missed wrap.

// File: rtl/usb_fs_pkg.sv
package usb_fs_pkg;

    // Boundary sequence: the order is behaviour, so the encoding is kept explicit.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SOF  = 2'd1,
        PH_PUB  = 2'd2,
        PH_FLAG = 2'd3
    } bnd_phase_e;

    localparam logic [1:0] ADDR_INTERVAL = 2'd0;
    localparam logic [1:0] ADDR_PSTART   = 2'd1;
    localparam logic [1:0] ADDR_LSTHR    = 2'd2;
    localparam logic [1:0] ADDR_STATUS   = 2'd3;

endpackage

// File: rtl/usb_fs_cfg.sv
module usb_fs_cfg
    import usb_fs_pkg::*;
#(
    parameter int REM_W        = 14,
    parameter int LS_W         = 11,
    parameter int DEF_INTERVAL = 11999,
    parameter int DEF_LS_THR   = 1576
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [REM_W-1:0] wdata,
    output logic [REM_W-1:0] interval,
    output logic [REM_W-1:0] pstart,
    output logic [LS_W-1:0]  lsthr,
    output logic             clr_sof
);

    typedef struct packed {
        logic [REM_W-1:0] interval;
        logic [REM_W-1:0] pstart;
        logic [LS_W-1:0]  lsthr;
        logic             locked;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (addr)
                ADDR_INTERVAL: cfg_d.interval = wdata;
                ADDR_PSTART:   cfg_d.pstart   = wdata;
                ADDR_LSTHR: begin
                    if (!cfg_q.locked) begin
                        cfg_d.lsthr  = wdata[LS_W-1:0];
                        cfg_d.locked = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.interval <= REM_W'(DEF_INTERVAL);
            cfg_q.pstart   <= '0;
            cfg_q.lsthr    <= LS_W'(DEF_LS_THR);
            cfg_q.locked   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign interval = cfg_q.interval;
    assign pstart   = cfg_q.pstart;
    assign lsthr    = cfg_q.lsthr;
    assign clr_sof  = wr && (addr == ADDR_STATUS) && wdata[0];

    assert_ls_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_q.locked) |-> $stable(cfg_q.lsthr));

endmodule

// File: rtl/usb_fs_frame.sv
module usb_fs_frame
    import usb_fs_pkg::*;
#(
    parameter int REM_W = 14,
    parameter int FN_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bit_tick,
    input  logic [REM_W-1:0] interval,
    input  logic             clr_sof,
    output logic [REM_W-1:0] rem,
    output logic [FN_W-1:0]  fn,
    output logic             running,
    output logic             reload,
    output logic             sof_pulse,
    output logic             pub_valid,
    output logic             seq_busy,
    output logic             sof_status
);

    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic [FN_W-1:0]  fn;
        logic             run;
        bnd_phase_e       phase;
        logic             status;
    } frm_t;

    frm_t frm_d, frm_q;

    always_comb begin
        frm_d     = frm_q;
        reload    = 1'b0;
        frm_d.run = run;
        if (!run) begin
            frm_d.rem   = '0;
            frm_d.phase = PH_IDLE;
        end else if (!frm_q.run || (bit_tick && (frm_q.rem == '0))) begin
            reload      = 1'b1;
            frm_d.rem   = interval;
            frm_d.fn    = frm_q.fn + FN_W'(1);
            frm_d.phase = PH_SOF;
        end else begin
            if (bit_tick) begin
                frm_d.rem = frm_q.rem - REM_W'(1);
            end
            case (frm_q.phase)
                PH_SOF:  frm_d.phase = PH_PUB;
                PH_PUB:  frm_d.phase = PH_FLAG;
                PH_FLAG: frm_d.phase = PH_IDLE;
                default: frm_d.phase = PH_IDLE;
            endcase
        end
        if (frm_q.phase == PH_FLAG) begin
            frm_d.status = 1'b1;
        end else if (clr_sof) begin
            frm_d.status = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q.rem    <= '0;
            frm_q.fn     <= '0;
            frm_q.run    <= 1'b0;
            frm_q.phase  <= PH_IDLE;
            frm_q.status <= 1'b0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign rem        = frm_q.rem;
    assign fn         = frm_q.fn;
    assign running    = frm_q.run;
    assign sof_pulse  = (frm_q.phase == PH_SOF);
    assign pub_valid  = (frm_q.phase == PH_PUB);
    assign seq_busy   = (frm_q.phase != PH_IDLE);
    assign sof_status = frm_q.status;

    assert_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frm_q.run) && frm_q.run && !$past(bit_tick)) |-> (frm_q.rem == $past(frm_q.rem)));

    assert_fn_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.fn != $past(frm_q.fn)) |-> (sof_pulse && (frm_q.fn == $past(frm_q.fn) + FN_W'(1))));

    assert_pub_after_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pub_valid |-> $past(sof_pulse));

    assert_flag_after_pub_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sof_status) |-> $past(pub_valid, 2));

endmodule

// File: rtl/usb_fs_arb.sv
module usb_fs_arb #(
    parameter int REM_W = 14,
    parameter int LS_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             reload,
    input  logic             seq_busy,
    input  logic             txn_busy,
    input  logic [REM_W-1:0] rem,
    input  logic [REM_W-1:0] pstart,
    input  logic [LS_W-1:0]  lsthr,
    output logic             cb_allow,
    output logic             per_grant,
    output logic             ls_ok,
    output logic             ls_denied
);

    typedef struct packed {
        logic pend;
        logic act;
        logic deny;
    } arb_t;

    arb_t arb_d, arb_q;
    logic [REM_W-1:0] ls_lim;
    logic             in_per_win;
    logic             in_ls_win;

    assign ls_lim     = REM_W'(lsthr);
    assign in_per_win = running && (rem <= pstart);
    assign in_ls_win  = running && (rem <= ls_lim);

    always_comb begin
        arb_d = arb_q;
        if (reload) begin
            arb_d = '0;
        end else begin
            if (in_per_win) begin
                arb_d.pend = 1'b1;
            end
            if (arb_q.pend && !txn_busy && !seq_busy) begin
                arb_d.act = 1'b1;
            end
            if (in_ls_win) begin
                arb_d.deny = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q <= '0;
        end else begin
            arb_q <= arb_d;
        end
    end

    assign cb_allow  = running && !arb_q.pend;
    assign per_grant = arb_q.act;
    assign ls_ok     = running && !arb_q.deny && (rem > ls_lim);
    assign ls_denied = arb_q.deny;

    assert_pend_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_q.pend) |-> $past(running && (rem <= pstart)));

    assert_grant_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_q.act) |-> ($past(arb_q.pend) && !$past(txn_busy) && !$past(seq_busy)));

    assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (!arb_q.pend && !arb_q.act));

    assert_ls_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q.deny && !reload) |=> arb_q.deny);

endmodule

// File: rtl/usb_frame_sched.sv
module usb_frame_sched #(
    parameter int REM_W        = 14,
    parameter int FN_W         = 16,
    parameter int LS_W         = 11,
    parameter int DEF_INTERVAL = 11999,
    parameter int DEF_LS_THR   = 1576
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_addr,
    input  logic [REM_W-1:0] cfg_wdata,
    input  logic             run,
    input  logic             bit_tick,
    input  logic             txn_busy,
    output logic [REM_W-1:0] remaining,
    output logic [FN_W-1:0]  frame_num,
    output logic             sof_pulse,
    output logic             fn_pub_valid,
    output logic             sof_status,
    output logic             cb_allow,
    output logic             per_grant,
    output logic             ls_ok,
    output logic             ls_denied
);

    logic [REM_W-1:0] interval;
    logic [REM_W-1:0] pstart;
    logic [LS_W-1:0]  lsthr;
    logic             clr_sof;
    logic             running;
    logic             reload;
    logic             seq_busy;

    usb_fs_cfg #(
        .REM_W        (REM_W),
        .LS_W         (LS_W),
        .DEF_INTERVAL (DEF_INTERVAL),
        .DEF_LS_THR   (DEF_LS_THR)
    ) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .interval (interval),
        .pstart   (pstart),
        .lsthr    (lsthr),
        .clr_sof  (clr_sof)
    );

    usb_fs_frame #(
        .REM_W (REM_W),
        .FN_W  (FN_W)
    ) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .bit_tick   (bit_tick),
        .interval   (interval),
        .clr_sof    (clr_sof),
        .rem        (remaining),
        .fn         (frame_num),
        .running    (running),
        .reload     (reload),
        .sof_pulse  (sof_pulse),
        .pub_valid  (fn_pub_valid),
        .seq_busy   (seq_busy),
        .sof_status (sof_status)
    );

    usb_fs_arb #(
        .REM_W (REM_W),
        .LS_W  (LS_W)
    ) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .reload    (reload),
        .seq_busy  (seq_busy),
        .txn_busy  (txn_busy),
        .rem       (remaining),
        .pstart    (pstart),
        .lsthr     (lsthr),
        .cb_allow  (cb_allow),
        .per_grant (per_grant),
        .ls_ok     (ls_ok),
        .ls_denied (ls_denied)
    );

endmodule

// File: tb/test_usb_frame_sched.sv
`timescale 1ns/1ps
module test_usb_frame_sched;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [1:0]  cfg_addr;
    logic [13:0] cfg_wdata;
    logic        run;
    logic        bit_tick;
    logic        txn_busy;
    logic [13:0] remaining;
    logic [15:0] frame_num;
    logic        sof_pulse;
    logic        fn_pub_valid;
    logic        sof_status;
    logic        cb_allow;
    logic        per_grant;
    logic        ls_ok;
    logic        ls_denied;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    usb_frame_sched i_usb_frame_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .run          (run),
        .bit_tick     (bit_tick),
        .txn_busy     (txn_busy),
        .remaining    (remaining),
        .frame_num    (frame_num),
        .sof_pulse    (sof_pulse),
        .fn_pub_valid (fn_pub_valid),
        .sof_status   (sof_status),
        .cb_allow     (cb_allow),
        .per_grant    (per_grant),
        .ls_ok        (ls_ok),
        .ls_denied    (ls_denied)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [13:0] d);
        cfg_wr    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        step(1);
        cfg_wr    = 1'b0;
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        cfg_wr    = 1'b0;
        cfg_addr  = 2'd0;
        cfg_wdata = '0;
        run       = 1'b0;
        bit_tick  = 1'b0;
        txn_busy  = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    // R1: reset state, default interval and zero periodic-start threshold
    task automatic t_reset_defaults();
        do_reset();
        check("R1", "remaining", remaining, 0);
        check("R1", "frame_num", frame_num, 0);
        check("R1", "sof_pulse", sof_pulse, 0);
        check("R1", "sof_status", sof_status, 0);
        check("R1", "per_grant", per_grant, 0);
        check("R1", "ls_ok", ls_ok, 0);
        run = 1'b1;
        step(1);
        check("R1", "default interval", remaining, 11999);
        check("R2", "fn after start", frame_num, 1);
        bit_tick = 1'b1;
        step(11998);
        check("R3", "countdown", remaining, 1);
        check("R1", "cb_allow at 1", cb_allow, 1);
        step(1);
        check("R1", "cb_allow at 0", cb_allow, 1);
        bit_tick = 1'b0;
        step(1);
        check("R3", "held at 0", remaining, 0);
        check("R1", "zero threshold pend", cb_allow, 0);
    endtask

    // R2 R3 R4 R5 R6: start, boundary order, ticking, reload, status clear
    task automatic t_frame_cycle();
        do_reset();
        cfg_write(2'd0, 14'd20);
        run = 1'b1;
        step(1);
        check("R2", "load interval", remaining, 20);
        check("R2", "fn advance", frame_num, 1);
        check("R5", "sof first", sof_pulse, 1);
        check("R5", "pub not yet", fn_pub_valid, 0);
        step(1);
        check("R5", "pub second", fn_pub_valid, 1);
        check("R5", "sof one cycle", sof_pulse, 0);
        step(1);
        check("R5", "status not yet", sof_status, 0);
        step(1);
        check("R5", "status set", sof_status, 1);
        step(3);
        check("R3", "no tick hold", remaining, 20);
        bit_tick = 1'b1;
        step(5);
        check("R3", "five ticks", remaining, 15);
        step(15);
        check("R4", "at zero", remaining, 0);
        check("R4", "fn before reload", frame_num, 1);
        step(1);
        check("R4", "reload value", remaining, 20);
        check("R4", "fn after reload", frame_num, 2);
        check("R5", "sof after reload", sof_pulse, 1);
        bit_tick = 1'b0;
        step(4);
        check("R6", "status set again", sof_status, 1);
        cfg_write(2'd3, 14'd0);
        check("R6", "write 0 ignored", sof_status, 1);
        cfg_write(2'd3, 14'd1);
        check("R6", "write 1 clears", sof_status, 0);
        step(2);
        check("R6", "stays clear", sof_status, 0);
    endtask

    // R7 R8 R9: periodic priority, busy wait, clear on reload, boundary wait
    task automatic t_periodic();
        do_reset();
        cfg_write(2'd0, 14'd20);
        cfg_write(2'd1, 14'd8);
        run = 1'b1;
        step(4);
        bit_tick = 1'b1;
        txn_busy = 1'b1;
        step(12);
        check("R7", "rem at threshold", remaining, 8);
        check("R7", "cb still allowed", cb_allow, 1);
        step(1);
        check("R7", "cb blocked", cb_allow, 0);
        bit_tick = 1'b0;
        step(3);
        check("R8", "no grant while busy", per_grant, 0);
        txn_busy = 1'b0;
        step(1);
        check("R8", "grant after busy", per_grant, 1);
        bit_tick = 1'b1;
        step(7);
        check("R9", "grant held in frame", per_grant, 1);
        step(1);
        check("R9", "reloaded", remaining, 20);
        check("R9", "grant cleared", per_grant, 0);
        check("R9", "cb restored", cb_allow, 1);
        bit_tick = 1'b0;

        do_reset();
        cfg_write(2'd0, 14'd20);
        cfg_write(2'd1, 14'd20);
        run = 1'b1;
        step(2);
        check("R7", "pend at start", cb_allow, 0);
        step(2);
        check("R8", "no grant in sequence", per_grant, 0);
        step(1);
        check("R8", "grant after sequence", per_grant, 1);
    endtask

    // R10 R11: low-speed window and threshold lock
    task automatic t_low_speed();
        do_reset();
        cfg_write(2'd0, 14'd20);
        cfg_write(2'd2, 14'd10);
        run = 1'b1;
        step(1);
        check("R10", "ok at frame start", ls_ok, 1);
        bit_tick = 1'b1;
        step(9);
        check("R10", "ok above threshold", ls_ok, 1);
        check("R10", "no denial yet", ls_denied, 0);
        step(1);
        check("R10", "closed at threshold", ls_ok, 0);
        step(1);
        check("R10", "denied", ls_denied, 1);
        step(9);
        check("R10", "denial held", ls_denied, 1);
        step(1);
        check("R10", "denial cleared", ls_denied, 0);
        check("R10", "ok new frame", ls_ok, 1);
        bit_tick = 1'b0;
        cfg_write(2'd2, 14'd3);
        bit_tick = 1'b1;
        step(11);
        check("R11", "rem probe", remaining, 9);
        check("R11", "second write ignored", ls_ok, 0);
        bit_tick = 1'b0;
    endtask

    // R4: frame number wrap with one frame per clock
    task automatic t_wrap();
        int guard;
        do_reset();
        cfg_write(2'd0, 14'd0);
        run      = 1'b1;
        bit_tick = 1'b1;
        step(1);
        check("R4", "fn first", frame_num, 1);
        guard = 0;
        while (frame_num != 16'hFFFF && guard < 70000) begin
            step(1);
            guard++;
        end
        check("R4", "reached max", frame_num, 16'hFFFF);
        step(1);
        check("R4", "wrap to zero", frame_num, 0);
        bit_tick = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_defaults();
        t_frame_cycle();
        t_periodic();
        t_low_speed();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule